// File: doc/BRIEF.md
# Next Instruction Address Unit

This block owns the program counter of a small fixed-length 32-bit processor and chooses, on every clock edge, the address the next instruction is fetched from. Each cycle it looks at the instruction word being executed, the two register operands read for it, and a register value that serves as an indirect target. From these it advances sequentially, takes or skips a relative conditional branch, forms an absolute jump inside the current 256 MB region, follows a register-indirect jump, or performs a jump that also saves its return address.

For the save-return jump the block raises a write request toward the register file for the duration of that instruction's cycle. The request names the return-address register and carries the address of the instruction that follows. The register file, instruction memory and any pipeline control stay outside this block. One instruction is presented per clock.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` loads `pc` with the parameter `RESET_VEC` (default 0) on the next rising edge, whatever the instruction inputs hold.
- R2: Any instruction whose opcode (`instr[31:26]`) is not 000010, 000011, 000100 or 000101, and that is not opcode 000000 with function field `instr[5:0]` = 001000, advances `pc` by 4, modulo 2^32, and `jr_val` has no effect on it.
- R3: Opcode 000100 sets the next `pc` to `pc+4 + (sign-extended instr[15:0] × 4)` when `rs_val` equals `rt_val`, and to `pc+4` otherwise.
- R4: Opcode 000101 uses the same target as R3 but is taken when `rs_val` differs from `rt_val`, and falls through to `pc+4` when they are equal.
- R5: The branch offset reaches both extremes of its range, -32768 words (0x8000) and +32767 words (0x7FFF), with the sum wrapping modulo 2^32.
- R6: Opcode 000010 sets the next `pc` to `{bits 31..28 of pc+4, instr[25:0], 2'b00}`; the region bits come from `pc+4`, not from the current `pc`.
- R7: Opcode 000000 with function field 001000 loads `pc` with `jr_val`, with its two low bits cleared.
- R8: Opcode 000011 jumps to the same target as R6 and, in the cycle the instruction is presented, drives `link_we` high with `link_idx` = 31 and `link_data` = `pc+4`; `link_we` is low for every other instruction and during reset.
- R9: The two low bits of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word executed this cycle |
| rs_val | input | 32 | First register operand for the branch comparison |
| rt_val | input | 32 | Second register operand for the branch comparison |
| jr_val | input | 32 | Register value used as the indirect jump target |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request, high for one instruction |
| link_idx | output | 5 | Register index for the return-address write |
| link_data | output | 32 | Return address, the current pc plus 4 |

## Verification
On every cycle the assertions check that the next `pc` follows the relevant rule from the previous cycle's instruction and operands: the sequential step, both branch senses, the region-preserving jump and the masked indirect jump. They also check word alignment of `pc`, the reset vector, and that the return-address write appears exactly with the save-return opcode, carrying index 31 and `pc+4`. Only the bench's scenarios show the specific corner values: both offset extremes with wrap-around below zero, a jump whose region bits differ between `pc` and `pc+4` at the top of the address space, an unaligned indirect value, and reset arriving while a save-return jump is on the inputs.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_RTYPE  = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;
   localparam logic [OPC_W-1:0] OPC_JLINK  = 6'b000011;
   localparam logic [OPC_W-1:0] OPC_BR_EQ  = 6'b000100;
   localparam logic [OPC_W-1:0] OPC_BR_NE  = 6'b000101;
   localparam logic [5:0]       FN_REG_JMP = 6'b001000;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BR_EQ,
      FLOW_BR_NE,
      FLOW_JUMP,
      FLOW_JLINK,
      FLOW_REGJ
   } flow_t;

endpackage

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
   import npc_pkg::*;
#(
   parameter int OP_W = 6,
   parameter int FN_W = 6
) (
   input  logic [OP_W-1:0] op,
   input  logic [FN_W-1:0] fn,
   output flow_t           flow
);

   initial begin
      assert (OP_W == OPC_W) else $error("npc_decode: opcode width must match package");
      assert (FN_W == 6) else $error("npc_decode: function field must be 6 bits");
   end

   always_comb begin
      unique case (op)
         OPC_BR_EQ: flow = FLOW_BR_EQ;
         OPC_BR_NE: flow = FLOW_BR_NE;
         OPC_JUMP:  flow = FLOW_JUMP;
         OPC_JLINK: flow = FLOW_JLINK;
         OPC_RTYPE: flow = (fn == FN_REG_JMP) ? FLOW_REGJ : FLOW_SEQ;
         default:   flow = FLOW_SEQ;
      endcase
   end

endmodule

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int OFF_W    = 16,
   parameter int JF_W     = 26,
   parameter int SHIFT    = 2,
   parameter bit ALIGN_JR = 1'b1
) (
   input  logic [XLEN-1:0]  pc,
   input  flow_t            flow,
   input  logic [OFF_W-1:0] offset,
   input  logic [JF_W-1:0]  jfield,
   input  logic [XLEN-1:0]  opa,
   input  logic [XLEN-1:0]  opb,
   input  logic [XLEN-1:0]  ind,
   output logic [XLEN-1:0]  seq,
   output logic [XLEN-1:0]  nxt
);

   localparam int REGION_W = XLEN - JF_W - SHIFT;
   localparam int EXT_W    = XLEN - OFF_W - SHIFT;
   localparam logic [XLEN-1:0] STEP = XLEN'(1) << SHIFT;

   initial begin
      assert (REGION_W >= 1) else $error("npc_target: jump field leaves no region bits");
      assert (EXT_W >= 0) else $error("npc_target: branch offset too wide");
   end

   logic [XLEN-1:0] br_disp;
   logic [XLEN-1:0] br_dest;
   logic [XLEN-1:0] jp_dest;
   logic [XLEN-1:0] rj_dest;
   logic            same;

   assign seq     = pc + STEP;
   assign br_disp = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
   assign br_dest = seq + br_disp;
   assign jp_dest = {seq[XLEN-1 -: REGION_W], jfield, {SHIFT{1'b0}}};
   assign same    = (opa == opb);

   generate
      if (ALIGN_JR) begin : g_rj_mask
         assign rj_dest = {ind[XLEN-1:SHIFT], {SHIFT{1'b0}}};
      end else begin : g_rj_raw
         assign rj_dest = ind;
      end
   endgenerate

   always_comb begin
      unique case (flow)
         FLOW_BR_EQ: nxt = same  ? br_dest : seq;
         FLOW_BR_NE: nxt = !same ? br_dest : seq;
         FLOW_JUMP,
         FLOW_JLINK: nxt = jp_dest;
         FLOW_REGJ:  nxt = rj_dest;
         default:    nxt = seq;
      endcase
   end

endmodule

// File: rtl/npc_pcreg.sv
`timescale 1ns/1ps
module npc_pcreg #(
   parameter int                 XLEN      = 32,
   parameter logic [XLEN-1:0]    RESET_VEC = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [XLEN-1:0] nxt,
   output logic [XLEN-1:0] pc
);

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_VEC;
      else     pc <= nxt;
   end

endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
   import npc_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              OP_W      = 6,
   parameter int              FN_W      = 6,
   parameter int              OFF_W     = 16,
   parameter int              JF_W      = 26,
   parameter int              REG_IDX_W = 5,
   parameter int              LINK_REG  = 31,
   parameter bit              ALIGN_JR  = 1'b1,
   parameter logic [XLEN-1:0] RESET_VEC = '0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [XLEN-1:0]      instr,
   input  logic [XLEN-1:0]      rs_val,
   input  logic [XLEN-1:0]      rt_val,
   input  logic [XLEN-1:0]      jr_val,
   output logic [XLEN-1:0]      pc,
   output logic                 link_we,
   output logic [REG_IDX_W-1:0] link_idx,
   output logic [XLEN-1:0]      link_data
);

   localparam int SHIFT = 2;

   initial begin
      assert (XLEN == OP_W + JF_W) else $error("npc_unit: opcode and jump field must fill the word");
      assert (RESET_VEC[SHIFT-1:0] == '0) else $error("npc_unit: reset vector must be word aligned");
      assert (LINK_REG < (1 << REG_IDX_W)) else $error("npc_unit: link register index out of range");
   end

   flow_t           flow;
   logic [XLEN-1:0] seq;
   logic [XLEN-1:0] nxt;

   npc_decode #(
      .OP_W (OP_W),
      .FN_W (FN_W)
   ) u_dec (
      .op   (instr[XLEN-1 -: OP_W]),
      .fn   (instr[FN_W-1:0]),
      .flow (flow)
   );

   npc_target #(
      .XLEN     (XLEN),
      .OFF_W    (OFF_W),
      .JF_W     (JF_W),
      .SHIFT    (SHIFT),
      .ALIGN_JR (ALIGN_JR)
   ) u_tgt (
      .pc     (pc),
      .flow   (flow),
      .offset (instr[OFF_W-1:0]),
      .jfield (instr[JF_W-1:0]),
      .opa    (rs_val),
      .opb    (rt_val),
      .ind    (jr_val),
      .seq    (seq),
      .nxt    (nxt)
   );

   npc_pcreg #(
      .XLEN      (XLEN),
      .RESET_VEC (RESET_VEC)
   ) u_pc (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .pc  (pc)
   );

   assign link_we   = !rst && (flow == FLOW_JLINK);
   assign link_idx  = REG_IDX_W'(LINK_REG);
   assign link_data = seq;

endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
   parameter int              XLEN      = 32,
   parameter int              OP_W      = 6,
   parameter int              FN_W      = 6,
   parameter int              OFF_W     = 16,
   parameter int              JF_W      = 26,
   parameter int              REG_IDX_W = 5,
   parameter int              LINK_REG  = 31,
   parameter bit              ALIGN_JR  = 1'b1,
   parameter logic [XLEN-1:0] RESET_VEC = '0
) (
   input logic                 clk,
   input logic                 rst,
   input logic [XLEN-1:0]      instr,
   input logic [XLEN-1:0]      rs_val,
   input logic [XLEN-1:0]      rt_val,
   input logic [XLEN-1:0]      jr_val,
   input logic [XLEN-1:0]      pc,
   input logic                 link_we,
   input logic [REG_IDX_W-1:0] link_idx,
   input logic [XLEN-1:0]      link_data
);

   logic [OP_W-1:0] c_op;
   logic [FN_W-1:0] c_fn;
   logic [XLEN-1:0] c_step;
   logic [XLEN-1:0] c_disp;
   logic [XLEN-1:0] c_jmp;
   logic [XLEN-1:0] c_ind;
   logic            c_isj;
   logic            c_isl;
   logic            c_isr;
   logic            c_iseq;
   logic            c_isne;
   logic            c_plain;

   assign c_op    = instr[XLEN-1 -: OP_W];
   assign c_fn    = instr[FN_W-1:0];
   assign c_step  = pc + 32'd4;
   assign c_disp  = XLEN'($signed(instr[OFF_W-1:0])) <<< 2;
   assign c_jmp   = {c_step[XLEN-1 -: (XLEN-JF_W-2)], instr[JF_W-1:0], 2'b00};
   assign c_ind   = ALIGN_JR ? (jr_val & ~XLEN'(3)) : jr_val;
   assign c_isj   = (c_op == 6'b000010);
   assign c_isl   = (c_op == 6'b000011);
   assign c_iseq  = (c_op == 6'b000100);
   assign c_isne  = (c_op == 6'b000101);
   assign c_isr   = (c_op == 6'b000000) && (c_fn == 6'b001000);
   assign c_plain = !(c_isj || c_isl || c_iseq || c_isne || c_isr);

   assert_reset_vec_R1: assert property (@(posedge clk) rst |=> (pc == RESET_VEC));

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      c_plain |=> (pc == $past(c_step)));

   assert_br_eq_R3: assert property (@(posedge clk) disable iff (rst)
      (c_iseq && rs_val == rt_val) |=> (pc == $past(c_step + c_disp)));

   assert_br_eq_skip_R3: assert property (@(posedge clk) disable iff (rst)
      (c_iseq && rs_val != rt_val) |=> (pc == $past(c_step)));

   assert_br_ne_R4: assert property (@(posedge clk) disable iff (rst)
      (c_isne && rs_val != rt_val) |=> (pc == $past(c_step + c_disp)));

   assert_br_ne_skip_R4: assert property (@(posedge clk) disable iff (rst)
      (c_isne && rs_val == rt_val) |=> (pc == $past(c_step)));

   assert_jump_region_R6: assert property (@(posedge clk) disable iff (rst)
      (c_isj || c_isl) |=> (pc == $past(c_jmp)));

   assert_reg_jump_R7: assert property (@(posedge clk) disable iff (rst)
      c_isr |=> (pc == $past(c_ind)));

   assert_link_on_R8: assert property (@(posedge clk) disable iff (rst)
      c_isl |-> (link_we && link_idx == REG_IDX_W'(LINK_REG) && link_data == c_step));

   assert_link_off_R8: assert property (@(posedge clk) disable iff (rst)
      !c_isl |-> !link_we);

   generate
      if (ALIGN_JR) begin : g_align
         assert_pc_align_R9: assert property (@(posedge clk) disable iff (rst)
            pc[1:0] == 2'b00);
      end
   endgenerate

endmodule

bind npc_unit npc_unit_chk #(
   .XLEN      (XLEN),
   .OP_W      (OP_W),
   .FN_W      (FN_W),
   .OFF_W     (OFF_W),
   .JF_W      (JF_W),
   .REG_IDX_W (REG_IDX_W),
   .LINK_REG  (LINK_REG),
   .ALIGN_JR  (ALIGN_JR),
   .RESET_VEC (RESET_VEC)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .instr     (instr),
   .rs_val    (rs_val),
   .rt_val    (rt_val),
   .jr_val    (jr_val),
   .pc        (pc),
   .link_we   (link_we),
   .link_idx  (link_idx),
   .link_data (link_data)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;

   typedef struct packed {
      logic [23:0] tag;
      logic [31:0] ins;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] r;
      logic [31:0] nxt;
      logic        lk;
   } vec_t;

   localparam int NV = 16;

   localparam vec_t TBL [NV] = '{
      '{"R2 ", 32'h0232_4020, 32'd0, 32'd0, 32'd0,        32'h0000_0004, 1'b0},
      '{"R3 ", 32'h1000_0002, 32'd5, 32'd5, 32'd0,        32'h0000_0010, 1'b0},
      '{"R3 ", 32'h1000_0002, 32'd5, 32'd6, 32'd0,        32'h0000_0014, 1'b0},
      '{"R4 ", 32'h1400_FFFF, 32'd1, 32'd2, 32'd0,        32'h0000_0014, 1'b0},
      '{"R4 ", 32'h1400_0010, 32'd3, 32'd3, 32'd0,        32'h0000_0018, 1'b0},
      '{"R6 ", 32'h0800_4E20, 32'd0, 32'd0, 32'd0,        32'h0001_3880, 1'b0},
      '{"R8 ", 32'h0C00_0100, 32'd0, 32'd0, 32'd0,        32'h0000_0400, 1'b1},
      '{"R7 ", 32'h03E0_0008, 32'd0, 32'd0, 32'h0001_3884, 32'h0001_3884, 1'b0},
      '{"R5 ", 32'h1000_8000, 32'd7, 32'd7, 32'd0,        32'hFFFF_3888, 1'b0},
      '{"R6 ", 32'h0BFF_FFFF, 32'd0, 32'd0, 32'd0,        32'hFFFF_FFFC, 1'b0},
      '{"R6 ", 32'h0800_0010, 32'd0, 32'd0, 32'd0,        32'h0000_0040, 1'b0},
      '{"R5 ", 32'h1000_7FFF, 32'd9, 32'd9, 32'd0,        32'h0002_0040, 1'b0},
      '{"R7 ", 32'h0000_0008, 32'd0, 32'd0, 32'h0000_1237, 32'h0000_1234, 1'b0},
      '{"R8 ", 32'h0C00_0020, 32'd0, 32'd0, 32'd0,        32'h0000_0080, 1'b1},
      '{"R2 ", 32'h1800_0005, 32'd4, 32'd4, 32'd0,        32'h0000_0084, 1'b0},
      '{"R2 ", 32'h0000_0009, 32'd0, 32'd0, 32'h0000_5000, 32'h0000_0088, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] instr;
   logic [31:0] rs_val;
   logic [31:0] rt_val;
   logic [31:0] jr_val;
   logic [31:0] pc;
   logic        link_we;
   logic [4:0]  link_idx;
   logic [31:0] link_data;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic [31:0] exp_pc;

   always #2.5 clk = ~clk;

   npc_unit u0 (
      .clk       (clk),
      .rst       (rst),
      .instr     (instr),
      .rs_val    (rs_val),
      .rt_val    (rt_val),
      .jr_val    (jr_val),
      .pc        (pc),
      .link_we   (link_we),
      .link_idx  (link_idx),
      .link_data (link_data)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
      instr  = i;
      rs_val = a;
      rt_val = b;
      jr_val = r;
   endtask

   initial begin
      rst = 1'b1;
      drive(32'h0C00_0100, 32'd0, 32'd0, 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "pc after reset", pc, 32'h0);
      check("R8", "link_we during reset", {31'd0, link_we}, 32'd0);
      drive(32'h0, 32'd0, 32'd0, 32'd0);
      rst = 1'b0;
      exp_pc = 32'h0;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].ins, TBL[i].a, TBL[i].b, TBL[i].r);
         #1;
         check(string'(TBL[i].tag), "link_we", {31'd0, link_we}, {31'd0, TBL[i].lk});
         if (TBL[i].lk) begin
            check("R8", "link_idx", {27'd0, link_idx}, 32'd31);
            check("R8", "link_data", link_data, exp_pc + 32'd4);
         end
         @(posedge clk);
         @(negedge clk);
         check(string'(TBL[i].tag), "next pc", pc, TBL[i].nxt);
         check("R9", "pc alignment", {30'd0, pc[1:0]}, 32'd0);
         exp_pc = TBL[i].nxt;
      end

      // R1: reset while a save-return jump sits on the inputs
      drive(32'h0C00_0020, 32'd0, 32'd0, 32'd0);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1", "pc after mid-run reset", pc, 32'h0);
      rst = 1'b0;

      // R4: inequality branch with zero offset, taken, lands on pc+4
      drive(32'h1400_0000, 32'd1, 32'd0, 32'd0);
      @(posedge clk);
      @(negedge clk);
      check("R4", "zero-offset taken branch", pc, 32'h4);

      // R3: equality branch backwards by one word from pc 4 lands on 4
      drive(32'h1000_FFFF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd0);
      @(posedge clk);
      @(negedge clk);
      check("R3", "self-loop branch", pc, 32'h4);

      // R7: indirect jump to the top word with low bits set
      drive(32'h0000_0008, 32'd0, 32'd0, 32'hFFFF_FFFF);
      @(posedge clk);
      @(negedge clk);
      check("R7", "indirect to top", pc, 32'hFFFF_FFFC);

      // R2: sequential step wraps to zero
      drive(32'h0232_4020, 32'd0, 32'd0, 32'h0000_0100);
      @(posedge clk);
      @(negedge clk);
      check("R2", "wrap to zero", pc, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule